// File: doc/BRIEF.md
# Dual Data Pointer Control Register

This block holds two 16-bit data pointers and the small control register that chooses between them. Bit 0 of the control register selects the active pointer. Every pointer access by the core goes to the selected pointer only: a byte write, a byte read, the increment, and the value driven on `ptr_out`. A second bit in the same register lets software request a full processor reset, as if an external or watchdog reset had occurred. The reset tree itself lies outside this block, which only emits a one-cycle request.

Software reaches the block through a byte-wide command bus. Address 0 is the control register. Addresses 1 and upward are the bytes of the selected pointer, least significant byte first. Each command is applied at one clock edge. Read data is combinational from the address.

Bit 2 of the control register is tied to zero. Because of this, an increment command on the whole register toggles the select bit, and any carry out of bit 1 is lost. This is the cheap way for the core to switch pointers without risking changes to the upper bits.

Top module: `dptr_bank_ctl`

## Requirements
- R1: Two independent pointers exist. Control bit 0 chooses the active one. `ptr_out` and `sel_out` show the active pointer and bit 0. A byte write changes only the active pointer; the other pointer keeps its value.
- R2: Control bit 2 always reads 0. Writing a 1 to it has no effect.
- R3: Command 2 (increment register) loads the control register with its read value plus 1, with bit 2 cleared. As a result, bit 0 toggles, bit 1 becomes bit1 XOR bit0, and bits 3 and up are unchanged.
- R4: A write to address 0 with bit 3 set raises `swrst_req` for exactly the next cycle. Bit 3 always reads 0. Bits 1 and 4 to 7 store the written value.
- R5: No command other than a write to address 0 with bit 3 set raises `swrst_req`. This includes the register increment.
- R6: Command 3 (increment pointer) adds 1 to the active pointer only. The value wraps from FFFFh to 0000h.
- R7: With command 1 (write), address 1 writes the low byte and address 2 writes the high byte of the active pointer, and reading those addresses returns the same bytes. Address 3 reads 0, and writes to it are ignored.
- R8: After reset, the control register and both pointers are 0, so pointer 0 is selected and `swrst_req` is low.
- R9: Command 0 (idle) changes no state. `bus_rdata` follows `bus_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cmd | input | 2 | 0 idle, 1 write, 2 increment register, 3 increment pointer |
| bus_addr | input | ADDR_W (2) | 0 control register, 1..PTR_W/8 active pointer bytes |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data for `bus_addr` |
| ptr_out | output | PTR_W (16) | Active pointer value |
| sel_out | output | 1 | Active pointer index (control bit 0) |
| swrst_req | output | 1 | One-cycle software reset request |

## Verification
The bench builds the block with its defaults: 8-bit register, 16-bit pointers, reset-request bit at 3, and a 2-bit address. With these values, the one unmapped address (3) sits inside the address space, so it can be exercised. A single byte write of FFh into each half brings the pointer wrap within reach in a few commands. Random writes to the control register flip the select bit often, so each pointer is written and incremented while the other must hold its value. Directed cases cover the register increment from 01h and 03h, where the carry from bit 0 reaches bit 1 and is then lost at the tied bit.

// File: rtl/dptr_bank_pkg.sv
package dptr_bank_pkg;

   // Bus command encoding.
   typedef enum logic [1:0] {
      CMD_IDLE    = 2'd0,
      CMD_WRITE   = 2'd1,
      CMD_INC_CTL = 2'd2,
      CMD_INC_PTR = 2'd3
   } dptr_cmd_e;

   // Number of pointers selected by the single select bit.
   localparam int NPTR     = 2;
   // Bit position that toggles on a register increment.
   localparam int SEL_BIT  = 0;
   // Tied-low bit that absorbs the increment carry.
   localparam int ZERO_BIT = 2;

   // Control bits that are never stored.
   function automatic logic [31:0] ctl_drop_mask(input int swrst_bit);
      return (32'd1 << ZERO_BIT) | (32'd1 << swrst_bit);
   endfunction

endpackage

// File: rtl/aux_ctl_reg.sv
module aux_ctl_reg
   import dptr_bank_pkg::*;
#(
   parameter int REG_W     = 8,
   parameter int SWRST_BIT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             inc_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] ctl_view,
   output logic             sel,
   output logic             swrst_pulse
);

   localparam logic [REG_W-1:0] KEEP_MASK = ~REG_W'(ctl_drop_mask(SWRST_BIT));

   generate
      if (SWRST_BIT <= ZERO_BIT || SWRST_BIT >= REG_W) begin : g_bad_swrst
         $error("aux_ctl_reg: SWRST_BIT must lie above the tied bit and inside the register");
      end
   endgenerate

   logic [REG_W-1:0] store_q;
   logic [REG_W-1:0] inc_val;
   logic             swrst_q;

   // Increment works on the read view, so the tied bit is 0 before and after.
   always_comb begin
      ctl_view = store_q & KEEP_MASK;
      inc_val  = (ctl_view + REG_W'(1)) & KEEP_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= '0;
         swrst_q <= 1'b0;
      end else begin
         swrst_q <= wr_en & wdata[SWRST_BIT];
         if (wr_en) begin
            store_q <= wdata & KEEP_MASK;
         end else if (inc_en) begin
            store_q <= inc_val;
         end
      end
   end

   assign sel         = ctl_view[SEL_BIT];
   assign swrst_pulse = swrst_q;

endmodule

// File: rtl/dptr_file.sv
module dptr_file
   import dptr_bank_pkg::*;
#(
   parameter int PTR_W  = 16,
   parameter int DATA_W = 8,
   parameter int IDX_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              byte_we,
   input  logic [IDX_W-1:0]  byte_idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              inc_en,
   output logic [PTR_W-1:0]  ptr_active
);

   logic [PTR_W-1:0] bank [NPTR];

   generate
      for (genvar g = 0; g < NPTR; g++) begin : g_ptr
         logic [PTR_W-1:0] q;
         logic             mine;

         assign mine = (sel == 1'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (mine && byte_we) begin
               q[byte_idx*DATA_W +: DATA_W] <= wdata;
            end else if (mine && inc_en) begin
               q <= q + PTR_W'(1);
            end
         end

         assign bank[g] = q;
      end
   endgenerate

   assign ptr_active = bank[sel];

endmodule

// File: rtl/dptr_bus_decode.sv
module dptr_bus_decode
   import dptr_bank_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PTR_W  = 16,
   parameter int ADDR_W = 2,
   parameter int IDX_W  = 1
) (
   input  logic [1:0]        bus_cmd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] ctl_view,
   input  logic [PTR_W-1:0]  ptr_active,
   output logic              ctl_wr,
   output logic              ctl_inc,
   output logic              ptr_wr,
   output logic              ptr_inc,
   output logic [IDX_W-1:0]  byte_idx,
   output logic [DATA_W-1:0] rdata
);

   localparam int PTR_BYTES = PTR_W / DATA_W;

   dptr_cmd_e   cmd;
   logic        hit_ctl;
   logic        hit_ptr;
   int unsigned a_int;

   always_comb begin
      cmd      = dptr_cmd_e'(bus_cmd);
      a_int    = 32'(bus_addr);
      hit_ctl  = (a_int == 0);
      hit_ptr  = (a_int != 0) && (a_int <= PTR_BYTES);
      byte_idx = hit_ptr ? IDX_W'(a_int - 1) : '0;

      ctl_wr  = (cmd == CMD_WRITE) && hit_ctl;
      ptr_wr  = (cmd == CMD_WRITE) && hit_ptr;
      ctl_inc = (cmd == CMD_INC_CTL);
      ptr_inc = (cmd == CMD_INC_PTR);

      rdata = '0;
      if (hit_ctl) begin
         rdata = ctl_view;
      end else if (hit_ptr) begin
         rdata = ptr_active[byte_idx*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/dptr_bank_ctl.sv
module dptr_bank_ctl
   import dptr_bank_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PTR_W     = 16,
   parameter int SWRST_BIT = 3,
   parameter int ADDR_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_cmd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [PTR_W-1:0]  ptr_out,
   output logic              sel_out,
   output logic              swrst_req
);

   localparam int PTR_BYTES = PTR_W / DATA_W;
   localparam int IDX_W     = (PTR_BYTES > 1) ? $clog2(PTR_BYTES) : 1;

   generate
      if (DATA_W < ZERO_BIT + 2) begin : g_bad_data
         $error("dptr_bank_ctl: DATA_W too narrow for the control layout");
      end
      if (PTR_W % DATA_W != 0 || PTR_W < DATA_W) begin : g_bad_ptr
         $error("dptr_bank_ctl: PTR_W must be a whole number of bytes");
      end
      if ((1 << ADDR_W) < PTR_BYTES + 1) begin : g_bad_addr
         $error("dptr_bank_ctl: ADDR_W cannot reach every pointer byte");
      end
   endgenerate

   logic              ctl_wr;
   logic              ctl_inc;
   logic              ptr_wr;
   logic              ptr_inc;
   logic [IDX_W-1:0]  byte_idx;
   logic [DATA_W-1:0] ctl_view;

   dptr_bus_decode #(
      .DATA_W(DATA_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
   ) dec_i (
      .bus_cmd    (bus_cmd),
      .bus_addr   (bus_addr),
      .ctl_view   (ctl_view),
      .ptr_active (ptr_out),
      .ctl_wr     (ctl_wr),
      .ctl_inc    (ctl_inc),
      .ptr_wr     (ptr_wr),
      .ptr_inc    (ptr_inc),
      .byte_idx   (byte_idx),
      .rdata      (bus_rdata)
   );

   aux_ctl_reg #(
      .REG_W(DATA_W), .SWRST_BIT(SWRST_BIT)
   ) ctl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (ctl_wr),
      .inc_en      (ctl_inc),
      .wdata       (bus_wdata),
      .ctl_view    (ctl_view),
      .sel         (sel_out),
      .swrst_pulse (swrst_req)
   );

   dptr_file #(
      .PTR_W(PTR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) ptr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (sel_out),
      .byte_we    (ptr_wr),
      .byte_idx   (byte_idx),
      .wdata      (bus_wdata),
      .inc_en     (ptr_inc),
      .ptr_active (ptr_out)
   );

endmodule

// File: rtl/dptr_bank_chk.sv
module dptr_bank_chk
   import dptr_bank_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PTR_W     = 16,
   parameter int SWRST_BIT = 3,
   parameter int ADDR_W    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_cmd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [PTR_W-1:0]  ptr_out,
   input logic              sel_out,
   input logic              swrst_req,
   input logic [DATA_W-1:0] ctl_view
);

   assert_zero_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_view[ZERO_BIT]);

   assert_inc_toggles_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == CMD_INC_CTL) |=> (sel_out != $past(sel_out)));

   assert_inc_keeps_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == CMD_INC_CTL) |=>
         (ctl_view[DATA_W-1:ZERO_BIT+1] == $past(ctl_view[DATA_W-1:ZERO_BIT+1])));

   assert_swrst_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_view[SWRST_BIT]);

   assert_swrst_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      swrst_req |-> $past(bus_cmd == CMD_WRITE && bus_addr == '0 && bus_wdata[SWRST_BIT]));

   assert_ptr_inc_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == CMD_INC_PTR) |=> (ptr_out == $past(ptr_out) + PTR_W'(1)));

   assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == CMD_IDLE) |=> ($stable(ptr_out) && $stable(ctl_view)));

endmodule

bind dptr_bank_ctl dptr_bank_chk #(
   .DATA_W(DATA_W), .PTR_W(PTR_W), .SWRST_BIT(SWRST_BIT), .ADDR_W(ADDR_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_cmd   (bus_cmd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .ptr_out   (ptr_out),
   .sel_out   (sel_out),
   .swrst_req (swrst_req),
   .ctl_view  (ctl_view)
);

// File: tb/dptr_bank_ctl_tb_top.sv
module dptr_bank_ctl_tb_top;

   localparam logic [7:0] MASK = 8'hF3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_cmd = 2'd0;
   logic [1:0]  bus_addr = 2'd0;
   logic [7:0]  bus_wdata = 8'd0;
   logic [7:0]  bus_rdata;
   logic [15:0] ptr_out;
   logic        sel_out;
   logic        swrst_req;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [7:0]  m_ctl;
   logic [15:0] m_ptr [2];
   logic        m_sw;

   always #5 clk = ~clk;

   dptr_bank_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ptr_out(ptr_out),
      .sel_out(sel_out), .swrst_req(swrst_req)
   );

   function automatic logic [7:0] f_ctl_inc(input logic [7:0] c);
      return (c + 8'd1) & MASK;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Compare every visible output against the model; called at a negedge with idle command.
   task automatic check_all(input string req);
      chk({req, " sel"}, 32'(sel_out), 32'(m_ctl[0]));
      chk({req, " ptr"}, 32'(ptr_out), 32'(m_ptr[m_ctl[0]]));
      bus_addr = 2'd0; #1;
      chk({req, " ctl read"}, 32'(bus_rdata), 32'(m_ctl));
      bus_addr = 2'd1; #1;
      chk({req, " low read R7"}, 32'(bus_rdata), 32'(m_ptr[m_ctl[0]][7:0]));
      bus_addr = 2'd2; #1;
      chk({req, " high read R9"}, 32'(bus_rdata), 32'(m_ptr[m_ctl[0]][15:8]));
      bus_addr = 2'd3; #1;
      chk({req, " unmapped read R7"}, 32'(bus_rdata), 32'd0);
   endtask

   // Issue one command from a negedge; returns at a negedge.
   task automatic op(input logic [1:0] cmd, input logic [1:0] a, input logic [7:0] wd,
                     input string req);
      bus_cmd = cmd; bus_addr = a; bus_wdata = wd;
      m_sw = 1'b0;
      case (cmd)
         2'd1: begin
            if (a == 2'd0) begin
               m_ctl = wd & MASK;
               m_sw  = wd[3];
            end else if (a == 2'd1) m_ptr[m_ctl[0]][7:0]  = wd;
            else if (a == 2'd2)     m_ptr[m_ctl[0]][15:8] = wd;
         end
         2'd2: m_ctl = f_ctl_inc(m_ctl);
         2'd3: m_ptr[m_ctl[0]] = m_ptr[m_ctl[0]] + 16'd1;
         default: ;
      endcase
      @(posedge clk); @(negedge clk);
      bus_cmd = 2'd0;
      chk({req, " swrst R4 R5"}, 32'(swrst_req), 32'(m_sw));
      check_all(req);
      @(posedge clk); @(negedge clk);
      chk({req, " swrst one cycle R4"}, 32'(swrst_req), 32'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [15:0] other;
      m_ctl = 8'd0; m_ptr[0] = 16'd0; m_ptr[1] = 16'd0; m_sw = 1'b0;
      void'($urandom(32'd20417));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset values
      chk("R8 swrst", 32'(swrst_req), 32'd0);
      check_all("R8");

      // R2 R4: all ones into the control register
      op(2'd1, 2'd0, 8'hFF, "R2 R4 write ff");
      // R3: increment from bit0=1 bit1=1 -> carry lost at tied bit
      op(2'd1, 2'd0, 8'h03, "R3 set 03");
      op(2'd2, 2'd0, 8'h00, "R3 inc from 03");
      chk("R3 value after inc", 32'(m_ctl), 32'h00);
      op(2'd1, 2'd0, 8'hF1, "R3 set f1");
      op(2'd2, 2'd0, 8'h00, "R3 inc from f1 R5");
      op(2'd2, 2'd0, 8'h00, "R3 inc from f2");

      // R6: wrap of pointer 1 while pointer 0 held (R1)
      op(2'd1, 2'd0, 8'h01, "R1 select 1");
      op(2'd1, 2'd1, 8'hFF, "R7 low byte");
      op(2'd1, 2'd2, 8'hFF, "R7 high byte");
      op(2'd1, 2'd3, 8'h5A, "R7 unmapped write");
      op(2'd3, 2'd0, 8'h00, "R6 wrap");
      op(2'd3, 2'd0, 8'h00, "R6 after wrap");
      other = m_ptr[0];
      op(2'd2, 2'd0, 8'h00, "R1 toggle back");
      chk("R1 other pointer held", 32'(ptr_out), 32'(other));

      // Random mix
      for (int i = 0; i < 400; i++) begin
         logic [1:0] c;
         c = 2'($urandom_range(0, 3));
         op(c, 2'($urandom_range(0, 3)), 8'($urandom), "R1 R9 random");
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule